// File: doc/BRIEF.md
# Transmit Segmentation Planner

This block consumes transmit descriptors one by one, in queue order, and assembles them into a send unit. A unit may open with one context descriptor. The rest of the unit is data descriptors, and it ends at the first data descriptor that carries the end-of-packet flag. The block keeps a running byte total, the segmentation settings and the header lengths. It stores no descriptor contents.

Once a unit is complete, the block plans the segments to send. A plain unit produces one segment that covers every byte. A unit with segmentation enabled produces a series of segments. Each segment carries the protocol header followed by at most one MSS of payload, and a running offset tracks how far the unit has been consumed.

Each segment is presented on a valid/ready port. The port gives the byte range taken from the unit, the segment length with the replayed header included, and the payload length. After the last segment, a release pulse reports how many descriptors the unit used. The queue then marks those descriptors done. A malformed unit is not planned: it is released with an error flag.

Top module: `tso_planner`

## Requirements
- R1: After reset, `desc_ready_o` is 1, and `seg_valid_o`, `rel_valid_o` and `err_o` are 0.
- R2: A descriptor is taken on a clock edge where both `desc_valid_i` and `desc_ready_o` are 1. Type code 0 means data and type code 1 means context. No segment is offered until a data descriptor with `desc_eop_i` set has been taken.
- R3: A context descriptor taken as the first descriptor of a unit sets the segmentation flag (`desc_tso_i`) and the MSS (`desc_mss_i`). It adds nothing to the byte total, but it counts in the release count. A context descriptor with the flag clear leads to a plain unit, and its MSS is ignored.
- R4: The header length is taken from the end-of-packet descriptor. It is 2 × `desc_mac_i` + 4 × `desc_ip_i` + 4 × `desc_l4_i` bytes.
- R5: A plain unit produces one segment with start 0, end = total, length = total, payload 0, and last = 1.
- R6: The first segment of a segmented unit has start 0 and end = min(header + MSS, total), and its length equals its end. Its payload is min(max(end − header, 0), MSS).
- R7: Each later segment starts at the previous segment's end, and its end is min(start + MSS, total). Its length is header + end − start and its payload is end − start. Last is set when end equals total.
- R8: While `seg_ready_i` is 0, an offered segment stays valid and keeps all of its fields unchanged.
- R9: One cycle after the last segment is accepted, `rel_valid_o` pulses for exactly one cycle. The pulse carries the count of all descriptors in the unit, context included. `desc_ready_o` is 1 again in the next cycle, and the next unit starts at offset 0.
- R10: A plain unit whose total exceeds `MTU` produces no segment and is released with `err_o` = 1. A total exactly equal to `MTU` is accepted.
- R11: A descriptor with type code 2 or 3, or a context descriptor that is not first in its unit, ends the unit at once. The unit is released with `err_o` = 1, and the count includes the offending descriptor.
- R12: A segmented unit with MSS 0 produces no segment and is released with `err_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor can be taken |
| desc_type_i | input | 2 | Descriptor type: 0 data, 1 context, 2 and 3 invalid |
| desc_eop_i | input | 1 | End-of-packet flag (data descriptor) |
| desc_tso_i | input | 1 | Segmentation enable (context descriptor) |
| desc_mss_i | input | MSS_W | Maximum payload per segment (context descriptor) |
| desc_len_i | input | BUF_W | Buffer byte count (data descriptor) |
| desc_mac_i | input | MAC_W | MAC header length in 2-byte units |
| desc_ip_i | input | IP_W | IP header length in 4-byte units |
| desc_l4_i | input | L4_W | L4 header length in 4-byte units |
| seg_valid_o | output | 1 | Segment plan offered |
| seg_ready_i | input | 1 | Segment plan accepted |
| seg_start_o | output | LEN_W | First unit byte taken by this segment |
| seg_end_o | output | LEN_W | Unit byte offset one past the last byte taken |
| seg_len_o | output | LEN_W | Segment length, replayed header included |
| seg_pay_o | output | LEN_W | Payload bytes in this segment |
| seg_last_o | output | 1 | Final segment of the unit |
| rel_valid_o | output | 1 | Unit finished, descriptors to be released |
| rel_count_o | output | CNT_W | Number of descriptors released |
| err_o | output | 1 | Unit discarded as malformed (valid with rel_valid_o) |

## Verification
The bench keeps the default widths and sets `MTU` to 512. This lets small buffers reach the MTU boundary from both sides, 512 and 513 bytes. The segmentation cases cover several cases:
- an MSS that divides the payload unevenly, giving a 4-segment unit with an 8-byte tail;
- two different header mixes;
- a header longer than the whole unit.

Back-pressure is applied to the segment port while a plan is pending. The bench also sends units with a misplaced context, with invalid type codes and with MSS 0. It checks that each is released with an error and that no segment is offered.

// File: rtl/tso_pkg.sv
package tso_pkg;
  localparam logic [1:0] DT_DATA = 2'd0;
  localparam logic [1:0] DT_CTX  = 2'd1;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_EMIT    = 2'd1,
    ST_REL     = 2'd2
  } plan_state_e;
endpackage

// File: rtl/tso_unit_acc.sv
module tso_unit_acc
  import tso_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BUF_W = 14,
  parameter int MSS_W = 14,
  parameter int CNT_W = 6,
  parameter int MAC_W = 7,
  parameter int IP_W  = 7,
  parameter int L4_W  = 4,
  parameter int MTU   = 1514
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clear_i,
  input  logic [1:0]       desc_type_i,
  input  logic             desc_eop_i,
  input  logic             desc_tso_i,
  input  logic [MSS_W-1:0] desc_mss_i,
  input  logic [BUF_W-1:0] desc_len_i,
  input  logic [MAC_W-1:0] desc_mac_i,
  input  logic [IP_W-1:0]  desc_ip_i,
  input  logic [L4_W-1:0]  desc_l4_i,
  output logic             tso_o,
  output logic [LEN_W-1:0] mss_o,
  output logic [LEN_W-1:0] total_o,
  output logic [LEN_W-1:0] hdr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             bad_o
);
  localparam logic [LEN_W-1:0] MTU_L = LEN_W'(MTU);

  logic             tso_q;
  logic [MSS_W-1:0] mss_q;
  logic [LEN_W-1:0] total_q, hdr_q, total_nx, hdr_nx;
  logic [CNT_W-1:0] cnt_q;
  logic is_data, ctx_ok, eop_hit, mtu_bad, mss_bad;

  assign is_data  = desc_type_i == DT_DATA;
  assign ctx_ok   = (desc_type_i == DT_CTX) && (cnt_q == '0);
  assign eop_hit  = is_data && desc_eop_i;
  assign total_nx = total_q + LEN_W'(desc_len_i);
  assign hdr_nx   = (LEN_W'(desc_mac_i) << 1) + (LEN_W'(desc_ip_i) << 2)
                  + (LEN_W'(desc_l4_i) << 2);
  assign mtu_bad  = eop_hit && !tso_q && (total_nx > MTU_L);
  assign mss_bad  = eop_hit && tso_q && (mss_q == '0);

  assign bad_o  = take_i && ((!is_data && !ctx_ok) || mtu_bad || mss_bad);
  assign done_o = take_i && eop_hit && !mtu_bad && !mss_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tso_q <= 1'b0; mss_q <= '0; total_q <= '0; hdr_q <= '0; cnt_q <= '0;
    end else if (clear_i) begin
      tso_q <= 1'b0; mss_q <= '0; total_q <= '0; hdr_q <= '0; cnt_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (ctx_ok) begin
        tso_q <= desc_tso_i;
        mss_q <= desc_mss_i;
      end
      if (is_data) total_q <= total_nx;
      if (eop_hit) hdr_q <= hdr_nx;
    end
  end

  assign tso_o   = tso_q;
  assign mss_o   = LEN_W'(mss_q);
  assign total_o = total_q;
  assign hdr_o   = hdr_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/tso_seg_plan.sv
module tso_seg_plan #(
  parameter int LEN_W = 16
) (
  input  logic             tso_i,
  input  logic             first_i,
  input  logic [LEN_W-1:0] off_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic [LEN_W-1:0] hdr_i,
  input  logic [LEN_W-1:0] mss_i,
  output logic [LEN_W-1:0] start_o,
  output logic [LEN_W-1:0] end_o,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] pay_o,
  output logic             last_o
);
  logic [LEN_W:0]   lim;
  logic [LEN_W-1:0] end_t, start_t, held, len_t, body;

  always_comb begin
    lim     = first_i ? ({1'b0, hdr_i} + {1'b0, mss_i}) : ({1'b0, off_i} + {1'b0, mss_i});
    end_t   = (lim > {1'b0, total_i}) ? total_i : lim[LEN_W-1:0];
    start_t = first_i ? '0 : off_i;
    held    = first_i ? '0 : hdr_i;
    len_t   = held + (end_t - start_t);
    body    = (len_t > hdr_i) ? (len_t - hdr_i) : '0;
    if (tso_i) begin
      start_o = start_t;
      end_o   = end_t;
      len_o   = len_t;
      pay_o   = (body > mss_i) ? mss_i : body;
      last_o  = end_t >= total_i;
    end else begin
      start_o = '0;
      end_o   = total_i;
      len_o   = total_i;
      pay_o   = '0;
      last_o  = 1'b1;
    end
  end
endmodule

// File: rtl/tso_planner.sv
module tso_planner
  import tso_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BUF_W = 14,
  parameter int MSS_W = 14,
  parameter int CNT_W = 6,
  parameter int MAC_W = 7,
  parameter int IP_W  = 7,
  parameter int L4_W  = 4,
  parameter int MTU   = 1514
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_valid_i,
  output logic             desc_ready_o,
  input  logic [1:0]       desc_type_i,
  input  logic             desc_eop_i,
  input  logic             desc_tso_i,
  input  logic [MSS_W-1:0] desc_mss_i,
  input  logic [BUF_W-1:0] desc_len_i,
  input  logic [MAC_W-1:0] desc_mac_i,
  input  logic [IP_W-1:0]  desc_ip_i,
  input  logic [L4_W-1:0]  desc_l4_i,
  output logic             seg_valid_o,
  input  logic             seg_ready_i,
  output logic [LEN_W-1:0] seg_start_o,
  output logic [LEN_W-1:0] seg_end_o,
  output logic [LEN_W-1:0] seg_len_o,
  output logic [LEN_W-1:0] seg_pay_o,
  output logic             seg_last_o,
  output logic             rel_valid_o,
  output logic [CNT_W-1:0] rel_count_o,
  output logic             err_o
);
  plan_state_e      state_q;
  logic [LEN_W-1:0] off_q;
  logic             first_q, err_q;
  logic             take, clear, done, bad, tso;
  logic [LEN_W-1:0] mss, total, hdr;
  logic [CNT_W-1:0] cnt;

  assign take  = desc_valid_i && desc_ready_o;
  assign clear = state_q == ST_REL;

  tso_unit_acc #(
    .LEN_W(LEN_W), .BUF_W(BUF_W), .MSS_W(MSS_W), .CNT_W(CNT_W),
    .MAC_W(MAC_W), .IP_W(IP_W), .L4_W(L4_W), .MTU(MTU)
  ) u_acc (
    .clk_i, .rst_ni,
    .take_i(take), .clear_i(clear),
    .desc_type_i, .desc_eop_i, .desc_tso_i, .desc_mss_i, .desc_len_i,
    .desc_mac_i, .desc_ip_i, .desc_l4_i,
    .tso_o(tso), .mss_o(mss), .total_o(total), .hdr_o(hdr), .cnt_o(cnt),
    .done_o(done), .bad_o(bad)
  );

  tso_seg_plan #(.LEN_W(LEN_W)) u_plan (
    .tso_i(tso), .first_i(first_q), .off_i(off_q), .total_i(total),
    .hdr_i(hdr), .mss_i(mss),
    .start_o(seg_start_o), .end_o(seg_end_o), .len_o(seg_len_o),
    .pay_o(seg_pay_o), .last_o(seg_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      off_q   <= '0;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_COLLECT: begin
          if (bad) begin
            state_q <= ST_REL;
            err_q   <= 1'b1;
          end else if (done) begin
            state_q <= ST_EMIT;
            off_q   <= '0;
            first_q <= 1'b1;
          end
        end
        ST_EMIT: begin
          if (seg_ready_i) begin
            off_q   <= seg_end_o;
            first_q <= 1'b0;
            if (seg_last_o) state_q <= ST_REL;
          end
        end
        ST_REL: begin
          state_q <= ST_COLLECT;
          err_q   <= 1'b0;
          off_q   <= '0;
          first_q <= 1'b1;
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign desc_ready_o = state_q == ST_COLLECT;
  assign seg_valid_o  = state_q == ST_EMIT;
  assign rel_valid_o  = state_q == ST_REL;
  assign rel_count_o  = cnt;
  assign err_o        = rel_valid_o && err_q;

  // R2
  seg_after_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seg_valid_o) |-> $past(desc_valid_i && desc_ready_o && desc_eop_i));

  // R7
  seg_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && seg_ready_i && !seg_last_o |=> seg_valid_o && seg_start_o == $past(seg_end_o));

  // R7
  pay_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && tso |-> seg_pay_o <= mss && seg_end_o <= total);

  // R8
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_start_o)
      && $stable(seg_end_o) && $stable(seg_len_o) && $stable(seg_pay_o));

  // R9
  rel_then_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_o |=> desc_ready_o && !rel_valid_o);

  // R11
  bad_type_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && desc_ready_o && desc_type_i[1] |=> err_o);
endmodule

// File: tb/tb_tso_planner.sv
module tb_tso_planner;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int CNT_W = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic desc_valid_i = 1'b0;
  logic desc_ready_o;
  logic [1:0] desc_type_i = '0;
  logic desc_eop_i = 1'b0, desc_tso_i = 1'b0;
  logic [13:0] desc_mss_i = '0, desc_len_i = '0;
  logic [6:0] desc_mac_i = '0, desc_ip_i = '0;
  logic [3:0] desc_l4_i = '0;
  logic seg_valid_o, seg_ready_i = 1'b1, seg_last_o;
  logic [LEN_W-1:0] seg_start_o, seg_end_o, seg_len_o, seg_pay_o;
  logic rel_valid_o, err_o;
  logic [CNT_W-1:0] rel_count_o;

  tso_planner #(.MTU(512)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int s_st[16], s_en[16], s_ln[16], s_py[16], s_la[16];
  int n_seg = 0, rel_n = 0, rel_c = 0, rel_e = 0;

  always @(negedge clk_i) begin
    if (seg_valid_o && seg_ready_i && n_seg < 16) begin
      s_st[n_seg] = seg_start_o; s_en[n_seg] = seg_end_o; s_ln[n_seg] = seg_len_o;
      s_py[n_seg] = seg_pay_o;   s_la[n_seg] = seg_last_o;
      n_seg++;
    end
    if (rel_valid_o) begin
      rel_n++; rel_c = rel_count_o; rel_e = err_o;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: cycles=%0d expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_log();
    n_seg = 0; rel_n = 0; rel_c = 0; rel_e = 0;
  endtask

  task automatic push(input int ty, input bit eop, input bit ts, input int mss, input int len,
                      input int mac, input int ip, input int l4);
    desc_type_i = 2'(ty); desc_eop_i = eop; desc_tso_i = ts; desc_mss_i = 14'(mss);
    desc_len_i = 14'(len); desc_mac_i = 7'(mac); desc_ip_i = 7'(ip); desc_l4_i = 4'(l4);
    desc_valid_i = 1'b1;
    do @(negedge clk_i); while (!desc_ready_o);
    @(posedge clk_i); #1;
    desc_valid_i = 1'b0;
  endtask

  task automatic wait_rel(input string req, input int cnt, input int err, input int nseg);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk_i); #2;
      if (rel_n != 0) break;
    end
    chk(rel_n == 1, "R9", "release pulses", rel_n, 1);
    chk(rel_c == cnt, req, "release count", rel_c, cnt);
    chk(rel_e == err, req, "error flag", rel_e, err);
    chk(n_seg == nseg, req, "segment count", n_seg, nseg);
    chk(desc_ready_o == 1'b1, "R9", "ready after release", int'(desc_ready_o), 1);
  endtask

  task automatic exp_seg(input string req, input int i, input int st, input int en,
                         input int ln, input int py, input int la);
    chk(s_st[i] == st, req, $sformatf("seg%0d start", i), s_st[i], st);
    chk(s_en[i] == en, req, $sformatf("seg%0d end", i), s_en[i], en);
    chk(s_ln[i] == ln, req, $sformatf("seg%0d len", i), s_ln[i], ln);
    chk(s_py[i] == py, req, $sformatf("seg%0d pay", i), s_py[i], py);
    chk(s_la[i] == la, req, $sformatf("seg%0d last", i), s_la[i], la);
  endtask

  task automatic t_reset();
    chk(desc_ready_o == 1'b1, "R1", "ready", int'(desc_ready_o), 1);
    chk(seg_valid_o == 1'b0, "R1", "seg_valid", int'(seg_valid_o), 0);
    chk(rel_valid_o == 1'b0, "R1", "rel_valid", int'(rel_valid_o), 0);
    chk(err_o == 1'b0, "R1", "err", int'(err_o), 0);
  endtask

  task automatic t_plain();
    clr_log();
    push(0, 0, 0, 0, 100, 0, 0, 0);
    push(0, 1, 0, 0, 200, 7, 5, 5);
    wait_rel("R5", 2, 0, 1);
    exp_seg("R5", 0, 0, 300, 300, 0, 1);
  endtask

  task automatic t_tso_two();
    clr_log();
    push(1, 0, 1, 100, 0, 0, 0, 0);
    push(0, 0, 0, 0, 60, 0, 0, 0);
    push(0, 0, 0, 0, 100, 0, 0, 0);
    push(0, 1, 0, 0, 94, 7, 5, 5);
    wait_rel("R3", 4, 0, 2);
    exp_seg("R6", 0, 0, 154, 154, 100, 0);
    exp_seg("R7", 1, 154, 254, 154, 100, 1);
  endtask

  task automatic t_tso_four();
    clr_log();
    push(1, 0, 1, 64, 0, 0, 0, 0);
    push(0, 0, 0, 0, 60, 0, 0, 0);
    push(0, 0, 0, 0, 100, 0, 0, 0);
    push(0, 1, 0, 0, 94, 7, 5, 5);
    wait_rel("R7", 4, 0, 4);
    exp_seg("R6", 0, 0, 118, 118, 64, 0);
    exp_seg("R7", 1, 118, 182, 118, 64, 0);
    exp_seg("R7", 2, 182, 246, 118, 64, 0);
    exp_seg("R7", 3, 246, 254, 62, 8, 1);
  endtask

  task automatic t_hdr_mix();
    clr_log();
    push(1, 0, 1, 64, 0, 0, 0, 0);
    push(0, 1, 0, 0, 200, 9, 10, 8);
    wait_rel("R4", 2, 0, 2);
    exp_seg("R4", 0, 0, 154, 154, 64, 0);
    exp_seg("R4", 1, 154, 200, 136, 46, 1);
  endtask

  task automatic t_short();
    clr_log();
    push(1, 0, 1, 100, 0, 0, 0, 0);
    push(0, 1, 0, 0, 40, 7, 5, 5);
    wait_rel("R6", 2, 0, 1);
    exp_seg("R6", 0, 0, 40, 40, 0, 1);
  endtask

  task automatic t_ctx_plain();
    clr_log();
    push(1, 0, 0, 0, 0, 0, 0, 0);
    push(0, 1, 0, 0, 120, 7, 5, 5);
    wait_rel("R3", 2, 0, 1);
    exp_seg("R3", 0, 0, 120, 120, 0, 1);
  endtask

  task automatic t_mtu();
    clr_log();
    push(0, 0, 0, 0, 300, 0, 0, 0);
    push(0, 1, 0, 0, 212, 0, 0, 0);
    wait_rel("R10", 2, 0, 1);
    exp_seg("R10", 0, 0, 512, 512, 0, 1);
    clr_log();
    push(0, 0, 0, 0, 300, 0, 0, 0);
    push(0, 1, 0, 0, 213, 0, 0, 0);
    wait_rel("R10", 2, 1, 0);
  endtask

  task automatic t_bad_type();
    clr_log();
    push(0, 0, 0, 0, 50, 0, 0, 0);
    push(2, 0, 0, 0, 50, 0, 0, 0);
    wait_rel("R11", 2, 1, 0);
    clr_log();
    push(3, 1, 0, 0, 50, 0, 0, 0);
    wait_rel("R11", 1, 1, 0);
  endtask

  task automatic t_ctx_mid();
    clr_log();
    push(0, 0, 0, 0, 50, 0, 0, 0);
    push(1, 0, 1, 100, 0, 0, 0, 0);
    wait_rel("R11", 2, 1, 0);
  endtask

  task automatic t_mss0();
    clr_log();
    push(1, 0, 1, 0, 0, 0, 0, 0);
    push(0, 1, 0, 0, 100, 7, 5, 5);
    wait_rel("R12", 2, 1, 0);
  endtask

  task automatic t_no_eop();
    clr_log();
    push(0, 0, 0, 0, 40, 0, 0, 0);
    repeat (10) @(posedge clk_i);
    #2;
    chk(n_seg == 0, "R2", "segments before eop", n_seg, 0);
    chk(rel_n == 0, "R2", "release before eop", rel_n, 0);
    chk(desc_ready_o == 1'b1, "R2", "ready before eop", int'(desc_ready_o), 1);
    push(0, 1, 0, 0, 60, 0, 0, 0);
    wait_rel("R2", 2, 0, 1);
    exp_seg("R2", 0, 0, 100, 100, 0, 1);
  endtask

  task automatic t_stall();
    clr_log();
    seg_ready_i = 1'b0;
    push(1, 0, 1, 100, 0, 0, 0, 0);
    push(0, 1, 0, 0, 254, 7, 5, 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(seg_valid_o == 1'b1, "R8", "valid held", int'(seg_valid_o), 1);
      chk(seg_end_o == 154, "R8", "end held", int'(seg_end_o), 154);
      chk(seg_len_o == 154, "R8", "len held", int'(seg_len_o), 154);
    end
    chk(desc_ready_o == 1'b0, "R8", "ready while pending", int'(desc_ready_o), 0);
    @(posedge clk_i); #1;
    seg_ready_i = 1'b1;
    wait_rel("R8", 2, 0, 2);
    exp_seg("R8", 0, 0, 154, 154, 100, 0);
    exp_seg("R8", 1, 154, 254, 154, 100, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_plain();
    t_tso_two();
    t_tso_four();
    t_hdr_mix();
    t_short();
    t_ctx_plain();
    t_mtu();
    t_bad_type();
    t_ctx_mid();
    t_mss0();
    t_no_eop();
    t_stall();
    t_tso_two();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule